// File: doc/BRIEF.md
# Burst Address Splitter

The block turns one multi-transfer address request into a stream of single-transfer address requests. A request arrives on the input port with a start address, a burst kind, a length field and a transfer size. For each transfer in the burst the block presents one address on the output port, computed from the burst kind. Each output request is marked as a single transfer of the same size. A downstream engine that handles only one transfer per request can then serve multi-transfer requests without knowing their rules.

Both ports use valid/ready handshaking. A beat moves downstream only in a cycle where `out_valid` and `out_ready` are both high. The block holds no copy of the request. The upstream source keeps valid high and the request fields stable until it sees `in_ready`. The block raises `in_ready` only in the cycle in which the last beat of the burst is accepted downstream, so the request is consumed exactly when its final beat leaves. Back-pressure from the sink holds the current beat for any number of cycles. The source may drop valid between bursts. The output has no register stage: a request that appears on the input is offered as its first beat in the same cycle.

The wrap kind uses a modified rule. The offset is taken modulo (2^size × len), where len is the raw length field, and that offset is added to the start address exactly as given. Addresses are not first aligned to a wrap boundary.

Top module: `burst_beat_splitter`

## Requirements
- R1: Each accepted request produces exactly len+1 output beats, where len is the raw 8-bit length field. `in_ready` is high only in the cycle in which the final beat is transferred (`out_valid` and `out_ready` both high).
- R2: For burst code 2'b00 (fixed) and the reserved code 2'b11, every beat carries the start address unchanged.
- R3: For burst code 2'b01 (incrementing), beat i (counting from 0) carries start + i × 2^size, modulo 2^32.
- R4: For burst code 2'b10 (wrapping), beat i carries start + ((i × 2^size) mod (2^size × len)), modulo 2^32. With len = 0 the single beat carries the start address.
- R5: `out_valid` equals `in_valid`, so no beat is offered while no request is presented.
- R6: Every output beat has `out_len` = 0, `out_burst` = 2'b01, and `out_size` equal to `in_size`.
- R7: While a beat is offered and `out_ready` is low, the offered address does not change and the beat index does not advance, whatever the ready pattern.
- R8: After reset no beat is offered until a request arrives, and the first beat of the first request carries its start address.
- R9: After the final beat of a request, the next request starts again at beat 0, whether it arrives in the next cycle or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is presented |
| in_ready | output | 1 | Request consumed (final beat accepted this cycle) |
| in_addr | input | 32 | Start address |
| in_burst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 treated as fixed |
| in_len | input | 8 | Beats minus one |
| in_size | input | 3 | Log2 of bytes per transfer |
| out_valid | output | 1 | A beat is offered |
| out_ready | input | 1 | Sink accepts the offered beat |
| out_addr | output | 32 | Beat address |
| out_burst | output | 2 | Always 01 (single incrementing beat) |
| out_len | output | 8 | Always 0 |
| out_size | output | 3 | Copy of the request size |

## Verification
The bench sweeps all four burst codes over sizes 0 to 2, a set of short lengths and two start addresses. One start address is close to 2^32, so that address wrap-around is exercised. This separates the offset rules: fixed against reserved, a step of 2^size against a modulo step, and len-based wrapping against aligned wrapping. Each sweep runs under three sink patterns: always ready, alternating, and pseudo-random. These show that stalls neither skip nor repeat beats. Long bursts of length 254 check the counter at its top range. Requests come both back-to-back and with idle gaps, which checks that the beat index restarts at 0 for the next request.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;
endpackage

// File: rtl/bbs_beat_counter.sv
module bbs_beat_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] beat_idx,
  output logic [LEN_W-1:0] wrap_idx,
  output logic             last
);
  logic [LEN_W-1:0] wrap_nxt;

  assign last     = (beat_idx == len);
  assign wrap_nxt = wrap_idx + LEN_W'(1);

  // beat_idx counts 0..len; wrap_idx counts 0..len-1 and folds back,
  // which equals i mod len without a divider.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
      wrap_idx <= '0;
    end else if (step) begin
      if (last) begin
        beat_idx <= '0;
        wrap_idx <= '0;
      end else begin
        beat_idx <= beat_idx + LEN_W'(1);
        wrap_idx <= (wrap_nxt == len) ? '0 : wrap_nxt;
      end
    end
  end
endmodule

// File: rtl/bbs_addr_gen.sv
module bbs_addr_gen
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        kind,
  input  logic [SIZE_W-1:0] size,
  input  logic [LEN_W-1:0]  beat_idx,
  input  logic [LEN_W-1:0]  wrap_idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] incr_off;
  logic [ADDR_W-1:0] wrap_off;
  burst_kind_e       k;

  assign k        = burst_kind_e'(kind);
  assign incr_off = ADDR_W'(beat_idx) << size;
  assign wrap_off = ADDR_W'(wrap_idx) << size;

  always_comb begin
    unique case (k)
      BK_INCR: addr = base + incr_off;
      BK_WRAP: addr = base + wrap_off;
      default: addr = base;
    endcase
  end
endmodule

// File: rtl/burst_beat_splitter.sv
module burst_beat_splitter
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_burst,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [SIZE_W-1:0] in_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_burst,
  output logic [LEN_W-1:0]  out_len,
  output logic [SIZE_W-1:0] out_size
);
  logic             fire;
  logic             last;
  logic [LEN_W-1:0] beat_idx;
  logic [LEN_W-1:0] wrap_idx;

  assign out_valid = in_valid;
  assign fire      = out_valid & out_ready;
  assign in_ready  = fire & last;

  assign out_burst = BK_INCR;
  assign out_len   = '0;
  assign out_size  = in_size;

  bbs_beat_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fire),
    .len      (in_len),
    .beat_idx (beat_idx),
    .wrap_idx (wrap_idx),
    .last     (last)
  );

  bbs_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_agen (
    .base     (in_addr),
    .kind     (in_burst),
    .size     (in_size),
    .beat_idx (beat_idx),
    .wrap_idx (wrap_idx),
    .addr     (out_addr)
  );
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_burst,
  input logic [LEN_W-1:0]  in_len,
  input logic [SIZE_W-1:0] in_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_burst,
  input logic [LEN_W-1:0]  out_len,
  input logic [SIZE_W-1:0] out_size
);
  logic           fire;
  logic [LEN_W:0] seen;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                    seen <= '0;
    else if (in_valid && in_ready) seen <= '0;
    else if (fire)                 seen <= seen + (LEN_W+1)'(1);
  end

  p_beats_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (fire && seen == {1'b0, in_len}));

  p_fixed_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (in_burst == 2'b00 || in_burst == 2'b11)) |-> out_addr == in_addr);

  p_incr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_ready && in_burst == 2'b01) |=>
      (!out_valid || out_addr == $past(out_addr) + (ADDR_W'(1) << $past(in_size))));

  p_no_idle_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);

  p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == '0 && out_burst == 2'b01 && out_size == in_size));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!($stable(in_addr) && $stable(in_burst) && $stable(in_size) && $stable(in_len))
       || $stable(out_addr)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_valid || out_addr == in_addr));
endmodule

bind burst_beat_splitter bbs_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_burst(in_burst), .in_len(in_len), .in_size(in_size),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_burst(out_burst), .out_len(out_len), .out_size(out_size)
);

// File: tb/burst_beat_splitter_bench.sv
`timescale 1ns/1ps
module burst_beat_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_burst = '0;
  logic [7:0]  in_len = '0;
  logic [2:0]  in_size = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [1:0]  out_burst;
  logic [7:0]  out_len;
  logic [2:0]  out_size;

  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  burst_beat_splitter u_burst_beat_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_burst(in_burst), .in_len(in_len), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_burst(out_burst), .out_len(out_len), .out_size(out_size)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] kind, input logic [31:0] base,
                                           input int len, input int size, input int i);
    longint unit = longint'(1) << size;
    longint off;
    case (kind)
      2'b01:   off = i * unit;
      2'b10:   off = (len == 0) ? 0 : (i * unit) % (unit * len);
      default: off = 0;
    endcase
    return 32'((longint'(base) + off) & 64'hFFFF_FFFF);
  endfunction

  task automatic run_burst(input logic [1:0] kind, input logic [31:0] base,
                           input int len, input int size, input int pat, input bit gap);
    int beat = 0;
    int n = 0;
    string rq;
    rq = (kind == 2'b01) ? "R3" : (kind == 2'b10) ? "R4" : "R2";
    while (beat <= len) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = base;
      in_burst = kind;
      in_len   = 8'(len);
      in_size  = 3'(size);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (pat)
        0:       out_ready = 1'b1;
        1:       out_ready = n[0];
        default: out_ready = lfsr[0];
      endcase
      n++;
      #1;
      chk(out_valid == 1'b1, "R5 valid follows request", longint'(out_valid), 1);
      chk(out_len == 8'd0 && out_burst == 2'b01 && out_size == 3'(size),
          "R6 single-beat fields", longint'({out_len, out_burst, out_size}),
          longint'({8'd0, 2'b01, 3'(size)}));
      if (beat == 0)
        chk(out_addr == base, "R9 beat 0 restarts at start", out_addr, base);
      if (out_ready) begin
        chk(out_addr == exp_addr(kind, base, len, size, beat), rq, out_addr,
            exp_addr(kind, base, len, size, beat));
        chk(in_ready == (beat == len), "R1 ready on final beat", longint'(in_ready),
            longint'(beat == len));
        beat++;
      end else begin
        chk(out_addr == exp_addr(kind, base, len, size, beat), "R7 stall holds beat",
            out_addr, exp_addr(kind, base, len, size, beat));
        chk(in_ready == 1'b0, "R1 no ready during stall", longint'(in_ready), 0);
      end
    end
    if (gap) begin
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R5 no beat while idle", longint'(out_valid), 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 150000) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[6] = '{0, 1, 2, 3, 4, 7};
    logic [31:0] bases[2] = '{32'h0000_1004, 32'hFFFF_FFF2};
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R8 reset idle",
        longint'({out_valid, in_ready}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R8 idle after reset", longint'(out_valid), 0);
    // R8: first request after reset starts at its start address
    run_burst(2'b01, 32'h0000_0040, 3, 2, 0, 1'b1);
    for (int pat = 0; pat < 3; pat++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 3; s++)
          for (int li = 0; li < 6; li++)
            for (int b = 0; b < 2; b++)
              run_burst(2'(k), bases[b], lens[li], s, pat, (li % 2) == 1);
    run_burst(2'b01, 32'h0000_2000, 254, 2, 2, 1'b0);
    run_burst(2'b10, 32'h0000_0004, 254, 1, 2, 1'b0);
    run_burst(2'b10, 32'h0000_0004, 3, 1, 0, 1'b1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule